// File: doc/BRIEF.md
# External Bus Access-Mode Controller

This block decides, for each access on an external bus interface, how that access is timed and how the one shared acknowledge/ready pin behaves. Each channel carries its own configuration: a page field, a ready-select bit and a 6-bit wait field. A decoder for each channel turns these into one of four access modes, encoded as Normal = 0, Page = 1, External ACK = 2 and Ready = 3. When a request is accepted, the mode of the selected channel is latched. That mode then decides what ends each beat: the internal wait counter followed by a one-cycle internal acknowledge, a low level on the pin (External ACK), or a high level on the pin (Ready). The pin is read through a synchroniser before any of these levels is used.

One global select, `static_sel`, chooses the pin behaviour. When it is 0 (dynamic), the block drives the pin High while no access is active. During Normal and Page accesses it drives the internal acknowledge onto the pin. During External ACK and Ready accesses it releases the pin to the external device. When it is 1 (static), the block never drives the pin.

The controller is a five-state machine:

- **IDLE** waits for a request. An accepted request goes to COUNT for Normal and Page modes, or to WAITX for External ACK and Ready modes.
- **COUNT** runs the wait counter down to zero and then goes to IACK.
- **IACK** drives the internal acknowledge low for one cycle and ends the beat.
- **WAITX** lets the synchroniser settle and then waits for the external level that ends the beat.
- **GAP** is a one-cycle idle gap between split beats. It then returns to COUNT or WAITX.

At the end of a beat the machine goes to IDLE if no beats remain. Otherwise it goes to GAP if the request is being split, or it starts the next beat at once.

Top module: `xbus_mode_ctrl`

## Requirements
- R1: The mode of a channel comes from its page field (PM), its ready bit and its wait field (WT). PM = 0 with WT not 0x3F gives Normal (0). PM ≠ 0 with WT not 0x3F gives Page (1). PM = 0 with WT = 0x3F gives External ACK (2) when the ready bit is 0, and Ready (3) when it is 1. The mode of the accepted channel appears on `cur_mode` from the cycle after acceptance.
- R2: The reserved decode (PM ≠ 0 with WT = 0x3F) runs as Normal mode. Accepting a request on such a channel sets `cfg_err`, which stays set until reset.
- R3: With `static_sel` = 0 and no access active (IDLE or GAP), `ackrdy_oe` = 1 and `ackrdy_out` = 1.
- R4: With `static_sel` = 0, during a Normal or Page access the pin is driven and `ackrdy_out` is low only in the cycle that ends the beat.
- R5: With `static_sel` = 0, during an External ACK or Ready access `ackrdy_oe` = 0.
- R6: With `static_sel` = 1, `ackrdy_oe` is 0 in every cycle, and internal-timed accesses still end on time.
- R7: For a Normal or Page beat with wait value W, `beat_end` is high for exactly one cycle, W+2 cycles after the acceptance edge, together with `ackrdy_out` = 0.
- R8: An External ACK beat ends once the synchronised pin level is low. With the pin low from the first cycle of the beat, `beat_end` rises in the beat's third cycle.
- R9: A Ready beat ends once the synchronised pin level is high. During the first two cycles of a beat the synchroniser output is ignored, so a stale High left by the block's own idle drive does not end the beat.
- R10: `burst_ok` is 0 when the channel on `req_ch` decodes to Ready, and 1 otherwise, including the reserved decode.
- R11: A burst request (`req_burst` = 1, `req_extra` = N) on a channel that is not in Ready mode runs N+1 beats back to back, with `acc_active` staying high until `req_done`.
- R12: A burst request on a Ready channel is split into single beats with one idle GAP cycle between them (`acc_active` low), and it sets `split_seen`, which stays set until reset. Bursts in other modes do not set it.
- R13: `req_ready` is high only in IDLE. `req_done` marks the final beat of a request and always coincides with `beat_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_sel | input | 1 | Global pin behaviour: 0 = dynamic, 1 = static |
| cfg_pm | input | NUM_CH*PM_W | Page field of each channel, channel 0 in the low bits |
| cfg_rdy | input | NUM_CH | Ready-select bit of each channel |
| cfg_wait | input | NUM_CH*WAIT_W | Wait field of each channel |
| req_valid | input | 1 | Access request |
| req_ch | input | CH_W | Channel of the request |
| req_burst | input | 1 | Request is a burst |
| req_extra | input | BEAT_W | Number of extra beats in a burst |
| req_ready | output | 1 | Controller is idle and accepts a request |
| burst_ok | output | 1 | Bursts are allowed on the channel on `req_ch` |
| acc_active | output | 1 | An external beat is in progress |
| beat_end | output | 1 | The current beat ends in this cycle |
| req_done | output | 1 | The last beat of the request ends in this cycle |
| cur_mode | output | 2 | Latched access mode |
| cfg_err | output | 1 | Sticky flag: a reserved decode was used |
| split_seen | output | 1 | Sticky flag: a burst was split |
| ackrdy_in | input | 1 | Level seen on the shared pin |
| ackrdy_out | output | 1 | Value driven onto the shared pin |
| ackrdy_oe | output | 1 | Output enable for the shared pin |

## Verification
The checker watches the pin rules on every cycle:

- static mode never drives the pin;
- an idle dynamic pin is driven High;
- the pin is released during external-handshake accesses;
- a low internal acknowledge occurs only at a beat end and lasts one cycle;
- `req_done` always coincides with `beat_end`, and `req_ready` only appears when no beat is active;
- both sticky flags stay set.

Some behaviour only the bench's scenarios can show. These are the mode decode of each configuration pattern, the exact W+2 latency, the two-cycle synchroniser latency, and the immunity to a stale Ready level. They also include the beat counts and gap patterns of bursts that run back to back and of bursts that are split, and the reserved decode running at Normal timing.

// File: rtl/xbus_mode_pkg.sv
package xbus_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_PAGE   = 2'd1,
        MODE_EXTACK = 2'd2,
        MODE_READY  = 2'd3
    } acc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COUNT = 3'd1,
        ST_IACK  = 3'd2,
        ST_WAITX = 3'd3,
        ST_GAP   = 3'd4
    } ctl_state_e;

    // Modes whose beats are ended by the internal wait counter
    function automatic logic mode_is_internal(input acc_mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_PAGE);
    endfunction

endpackage

// File: rtl/xbus_mode_decode.sv
module xbus_mode_decode
    import xbus_mode_pkg::*;
#(
    parameter int PM_W   = 2,
    parameter int WAIT_W = 6
) (
    input  logic [PM_W-1:0]   pm,
    input  logic              rdy,
    input  logic [WAIT_W-1:0] wcyc,
    output acc_mode_e         mode,
    output logic              reserved
);

    logic pm_set;
    logic wait_full;

    always_comb begin
        pm_set    = |pm;
        wait_full = &wcyc;
        reserved  = 1'b0;
        mode      = MODE_NORMAL;
        unique case ({pm_set, wait_full})
            2'b00: mode = MODE_NORMAL;
            2'b10: mode = MODE_PAGE;
            2'b01: mode = rdy ? MODE_READY : MODE_EXTACK;
            2'b11: begin
                // Reserved combination falls back to Normal timing
                mode     = MODE_NORMAL;
                reserved = 1'b1;
            end
            default: mode = MODE_NORMAL;
        endcase
    end

endmodule

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shift_q;

    // Resets to High, the idle level of the shared pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d};
        end
    end

    assign q = shift_q[STAGES-1];

endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/xbus_mode_ctrl.sv
module xbus_mode_ctrl
    import xbus_mode_pkg::*;
#(
    parameter  int NUM_CH      = 4,
    parameter  int PM_W        = 2,
    parameter  int WAIT_W      = 6,
    parameter  int BEAT_W      = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     static_sel,
    input  logic [NUM_CH*PM_W-1:0]   cfg_pm,
    input  logic [NUM_CH-1:0]        cfg_rdy,
    input  logic [NUM_CH*WAIT_W-1:0] cfg_wait,
    input  logic                     req_valid,
    input  logic [CH_W-1:0]          req_ch,
    input  logic                     req_burst,
    input  logic [BEAT_W-1:0]        req_extra,
    output logic                     req_ready,
    output logic                     burst_ok,
    output logic                     acc_active,
    output logic                     beat_end,
    output logic                     req_done,
    output logic [1:0]               cur_mode,
    output logic                     cfg_err,
    output logic                     split_seen,
    input  logic                     ackrdy_in,
    output logic                     ackrdy_out,
    output logic                     ackrdy_oe
);

    localparam int SET_W = $clog2(SYNC_STAGES + 1);
    localparam logic [SET_W-1:0] SETTLE_INIT = SET_W'(SYNC_STAGES);

    // ---------------- per-channel decode ----------------
    acc_mode_e         ch_mode [NUM_CH];
    logic [WAIT_W-1:0] ch_wait [NUM_CH];
    logic [NUM_CH-1:0] ch_rsv;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign ch_wait[g] = cfg_wait[g*WAIT_W +: WAIT_W];
        xbus_mode_decode #(
            .PM_W   (PM_W),
            .WAIT_W (WAIT_W)
        ) u_dec (
            .pm       (cfg_pm[g*PM_W +: PM_W]),
            .rdy      (cfg_rdy[g]),
            .wcyc     (cfg_wait[g*WAIT_W +: WAIT_W]),
            .mode     (ch_mode[g]),
            .reserved (ch_rsv[g])
        );
    end

    acc_mode_e         sel_mode;
    logic              sel_rsv;
    logic [WAIT_W-1:0] sel_wait;

    always_comb begin
        sel_mode = ch_mode[req_ch];
        sel_rsv  = ch_rsv[req_ch];
        sel_wait = ch_wait[req_ch];
    end

    // ---------------- state and datapath registers ----------------
    ctl_state_e        state_q, state_d, after_end;
    acc_mode_e         mode_q;
    logic [WAIT_W-1:0] wait_q;
    logic [BEAT_W-1:0] left_q;
    logic              split_q;
    logic              cfg_err_q;
    logic              split_seen_q;
    logic [SET_W-1:0]  settle_q;

    logic accept;
    logic sync_lvl;
    logic ext_hit;
    logic beat_fin;
    logic more;
    logic start_next;
    logic cnt_zero;
    logic cnt_load;
    logic [WAIT_W-1:0] cnt_val;

    xbus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ackrdy_in),
        .q     (sync_lvl)
    );

    always_comb begin
        accept     = (state_q == ST_IDLE) && req_valid;
        ext_hit    = (settle_q == '0) &&
                     (((mode_q == MODE_EXTACK) && !sync_lvl) ||
                      ((mode_q == MODE_READY) && sync_lvl));
        beat_fin   = (state_q == ST_IACK) || ((state_q == ST_WAITX) && ext_hit);
        more       = (left_q != '0);
        start_next = (state_q == ST_GAP) || (beat_fin && more && !split_q);
        cnt_load   = accept || start_next;
        cnt_val    = accept ? sel_wait : wait_q;
    end

    xbus_wait_cnt #(
        .W (WAIT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .run      (state_q == ST_COUNT),
        .zero     (cnt_zero)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        if (!more) begin
            after_end = ST_IDLE;
        end else if (split_q) begin
            after_end = ST_GAP;
        end else begin
            after_end = mode_is_internal(mode_q) ? ST_COUNT : ST_WAITX;
        end

        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = mode_is_internal(sel_mode) ? ST_COUNT : ST_WAITX;
                end
            end
            ST_COUNT: begin
                if (cnt_zero) begin
                    state_d = ST_IACK;
                end
            end
            ST_IACK:  state_d = after_end;
            ST_WAITX: begin
                if (ext_hit) begin
                    state_d = after_end;
                end
            end
            ST_GAP:   state_d = mode_is_internal(mode_q) ? ST_COUNT : ST_WAITX;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- access context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= MODE_NORMAL;
            wait_q       <= '0;
            left_q       <= '0;
            split_q      <= 1'b0;
            cfg_err_q    <= 1'b0;
            split_seen_q <= 1'b0;
        end else if (accept) begin
            mode_q  <= sel_mode;
            wait_q  <= sel_wait;
            left_q  <= req_burst ? req_extra : '0;
            split_q <= req_burst && (sel_mode == MODE_READY);
            if (sel_rsv) begin
                cfg_err_q <= 1'b1;
            end
            if (req_burst && (sel_mode == MODE_READY)) begin
                split_seen_q <= 1'b1;
            end
        end else if (beat_fin && more) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Settle window: synchroniser output ignored for the first stages of a beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (cnt_load) begin
            settle_q <= SETTLE_INIT;
        end else if ((state_q == ST_WAITX) && (settle_q != '0)) begin
            settle_q <= settle_q - 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        acc_active = (state_q == ST_COUNT) || (state_q == ST_IACK) ||
                     (state_q == ST_WAITX);
        beat_end   = beat_fin;
        req_done   = beat_fin && !more;
        cur_mode   = mode_q;
        cfg_err    = cfg_err_q;
        split_seen = split_seen_q;
        burst_ok   = (sel_mode != MODE_READY);
        ackrdy_out = (state_q != ST_IACK);
        ackrdy_oe  = !static_sel && (!acc_active || mode_is_internal(mode_q));
    end

endmodule

// File: rtl/xbus_mode_ctrl_chk.sv
module xbus_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       static_sel,
    input logic       req_ready,
    input logic       acc_active,
    input logic       beat_end,
    input logic       req_done,
    input logic [1:0] cur_mode,
    input logic       cfg_err,
    input logic       split_seen,
    input logic       ackrdy_out,
    input logic       ackrdy_oe
);

    // R6
    static_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        static_sel |-> !ackrdy_oe);

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_sel && !acc_active) |-> (ackrdy_oe && ackrdy_out));

    // R5
    ext_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_sel && acc_active && cur_mode[1]) |-> !ackrdy_oe);

    // R4
    ack_low_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ackrdy_oe && !ackrdy_out) |-> beat_end);

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_end && !cur_mode[1]) |=> !beat_end);

    // R13
    done_is_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> beat_end);

    // R13
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !acc_active);

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R12
    split_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_seen |=> split_seen);

endmodule

bind xbus_mode_ctrl xbus_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .static_sel (static_sel),
    .req_ready  (req_ready),
    .acc_active (acc_active),
    .beat_end   (beat_end),
    .req_done   (req_done),
    .cur_mode   (cur_mode),
    .cfg_err    (cfg_err),
    .split_seen (split_seen),
    .ackrdy_out (ackrdy_out),
    .ackrdy_oe  (ackrdy_oe)
);

// File: tb/tb_xbus_mode_ctrl.sv
module tb_xbus_mode_ctrl;

    localparam int NUM_CH = 4;
    localparam int PM_W   = 2;
    localparam int WAIT_W = 6;
    localparam int BEAT_W = 4;

    localparam logic [1:0] M_NORMAL = 2'd0;
    localparam logic [1:0] M_PAGE   = 2'd1;
    localparam logic [1:0] M_EXTACK = 2'd2;
    localparam logic [1:0] M_READY  = 2'd3;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     static_sel = 1'b0;
    logic [NUM_CH*PM_W-1:0]   cfg_pm = '0;
    logic [NUM_CH-1:0]        cfg_rdy = '0;
    logic [NUM_CH*WAIT_W-1:0] cfg_wait = '0;
    logic                     req_valid = 1'b0;
    logic [1:0]               req_ch = '0;
    logic                     req_burst = 1'b0;
    logic [BEAT_W-1:0]        req_extra = '0;
    logic                     req_ready, burst_ok, acc_active, beat_end, req_done;
    logic [1:0]               cur_mode;
    logic                     cfg_err, split_seen;
    logic                     ackrdy_out, ackrdy_oe;
    logic                     ext_man = 1'b1;
    logic                     auto_resp = 1'b0;
    logic                     auto_lvl = 1'b1;
    logic                     pin_lvl;

    int checks = 0;
    int errors = 0;
    int beat_cnt = 0;

    typedef struct {
        logic [1:0] mode;
        int         beats;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    assign pin_lvl = ackrdy_oe ? ackrdy_out : (auto_resp ? auto_lvl : ext_man);

    xbus_mode_ctrl #(
        .NUM_CH (NUM_CH),
        .PM_W   (PM_W),
        .WAIT_W (WAIT_W),
        .BEAT_W (BEAT_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .static_sel (static_sel),
        .cfg_pm     (cfg_pm),
        .cfg_rdy    (cfg_rdy),
        .cfg_wait   (cfg_wait),
        .req_valid  (req_valid),
        .req_ch     (req_ch),
        .req_burst  (req_burst),
        .req_extra  (req_extra),
        .req_ready  (req_ready),
        .burst_ok   (burst_ok),
        .acc_active (acc_active),
        .beat_end   (beat_end),
        .req_done   (req_done),
        .cur_mode   (cur_mode),
        .cfg_err    (cfg_err),
        .split_seen (split_seen),
        .ackrdy_in  (pin_lvl),
        .ackrdy_out (ackrdy_out),
        .ackrdy_oe  (ackrdy_oe)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input int pm, input bit rdy, input int w);
        cfg_pm[ch*PM_W +: PM_W]       = PM_W'(pm);
        cfg_rdy[ch]                   = rdy;
        cfg_wait[ch*WAIT_W +: WAIT_W] = WAIT_W'(w);
    endtask

    // Driver: issues a request and pushes the expected result to the scoreboard.
    // Returns at the falling edge after the accepting rising edge.
    task automatic issue(input int ch, input bit burst, input int extra,
                         input logic [1:0] exp_mode);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_ch    = 2'(ch);
        req_burst = burst;
        req_extra = BEAT_W'(extra);
        req_valid = 1'b1;
        e.mode    = exp_mode;
        e.beats   = burst ? extra + 1 : 1;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        req_burst = 1'b0;
    endtask

    task automatic wait_done();
        while (!req_done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: counts beats and compares each completed request with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (beat_end) beat_cnt++;
            if (req_done) begin
                if (sbq.size() == 0) begin
                    chk_eq("R13 done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk_eq("R1 mode of completed request", int'(cur_mode), int'(e.mode));
                    chk_eq("R11 R12 beats per request", beat_cnt, e.beats);
                end
                beat_cnt = 0;
            end
        end
    end

    // Automatic external responder used for bursts
    always @(negedge clk) begin
        if (acc_active) auto_lvl <= (cur_mode == M_READY);
        else            auto_lvl <= (cur_mode != M_READY);
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int gap;
        set_ch(0, 0, 1'b0, 3);
        set_ch(1, 1, 1'b0, 2);
        set_ch(2, 0, 1'b0, 6'h3F);
        set_ch(3, 0, 1'b1, 6'h3F);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R3, R13)
        chk_eq("R13 reset req_ready", req_ready, 1);
        chk_eq("R13 reset acc_active", acc_active, 0);
        chk_eq("R3 reset pin oe", ackrdy_oe, 1);
        chk_eq("R3 reset pin level", ackrdy_out, 1);
        chk_eq("R2 reset cfg_err", cfg_err, 0);
        chk_eq("R12 reset split_seen", split_seen, 0);

        // R10 burst permission per channel
        for (int c = 0; c < NUM_CH; c++) begin
            req_ch = 2'(c);
            #1;
            chk_eq("R10 burst_ok", burst_ok, (c == 3) ? 0 : 1);
        end

        // R7 R4 Normal access, W=3
        issue(0, 1'b0, 0, M_NORMAL);
        chk_eq("R13 busy during access", req_ready, 0);
        chk_eq("R1 Normal mode latched", cur_mode, M_NORMAL);
        for (int i = 0; i <= 3; i++) begin
            chk_eq("R7 no early beat_end", beat_end, 0);
            chk_eq("R4 pin driven", ackrdy_oe, 1);
            chk_eq("R4 pin high before end", ackrdy_out, 1);
            @(negedge clk);
        end
        chk_eq("R7 beat_end at W+2", beat_end, 1);
        chk_eq("R4 internal ack low", ackrdy_out, 0);
        chk_eq("R13 done on last beat", req_done, 1);
        @(negedge clk);
        chk_eq("R13 ready after access", req_ready, 1);

        // R1 Page access
        issue(1, 1'b0, 0, M_PAGE);
        chk_eq("R1 Page mode latched", cur_mode, M_PAGE);
        wait_done();

        // R8 External ACK single access
        ext_man = 1'b1;
        issue(2, 1'b0, 0, M_EXTACK);
        chk_eq("R5 pin released ExtACK", ackrdy_oe, 0);
        chk_eq("R1 ExtACK mode latched", cur_mode, M_EXTACK);
        ext_man = 1'b0;
        @(negedge clk);
        chk_eq("R8 no end before sync", beat_end, 0);
        @(negedge clk);
        chk_eq("R8 end after sync", beat_end, 1);
        ext_man = 1'b1;
        repeat (3) @(negedge clk);

        // R9 Ready with stale high in the synchroniser
        ext_man = 1'b0;
        issue(3, 1'b0, 0, M_READY);
        chk_eq("R5 pin released Ready", ackrdy_oe, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk_eq("R9 stale level ignored", beat_end, 0);
        end
        ext_man = 1'b1;
        @(negedge clk);
        chk_eq("R9 no end one cycle after ready", beat_end, 0);
        @(negedge clk);
        chk_eq("R9 end after synced ready", beat_end, 1);
        ext_man = 1'b0;
        repeat (3) @(negedge clk);

        // R11 Page burst of 3 beats runs back to back
        issue(1, 1'b1, 2, M_PAGE);
        gap = 0;
        while (!req_done) begin
            if (!acc_active) gap++;
            @(negedge clk);
        end
        chk_eq("R11 Page burst no gap", gap, 0);
        @(negedge clk);
        chk_eq("R12 non-Ready burst leaves split_seen", split_seen, 0);

        // R11 ExtACK burst of 2 beats
        auto_resp = 1'b1;
        issue(2, 1'b1, 1, M_EXTACK);
        gap = 0;
        while (!req_done) begin
            if (!acc_active) gap++;
            @(negedge clk);
        end
        chk_eq("R11 ExtACK burst no gap", gap, 0);
        @(negedge clk);

        // R12 Ready burst is split
        issue(3, 1'b1, 2, M_READY);
        gap = 0;
        while (!req_done) begin
            if (!acc_active) gap++;
            @(negedge clk);
        end
        chk_eq("R12 one gap per split beat", gap, 2);
        @(negedge clk);
        chk_eq("R12 split_seen set", split_seen, 1);
        auto_resp = 1'b0;
        ext_man = 1'b1;
        repeat (3) @(negedge clk);

        // R2 reserved decode runs as Normal and raises cfg_err
        set_ch(1, 1, 1'b0, 6'h3F);
        req_ch = 2'd1;
        #1;
        chk_eq("R10 R2 reserved allows burst", burst_ok, 1);
        issue(1, 1'b0, 0, M_NORMAL);
        chk_eq("R2 reserved latched as Normal", cur_mode, M_NORMAL);
        chk_eq("R2 cfg_err raised", cfg_err, 1);
        wait_done();
        set_ch(1, 1, 1'b0, 2);
        issue(1, 1'b0, 0, M_PAGE);
        wait_done();
        chk_eq("R2 cfg_err sticky", cfg_err, 1);

        // R6 static behaviour
        static_sel = 1'b1;
        @(negedge clk);
        chk_eq("R6 idle not driven", ackrdy_oe, 0);
        issue(0, 1'b0, 0, M_NORMAL);
        for (int i = 0; i <= 3; i++) begin
            chk_eq("R6 access not driven", ackrdy_oe, 0);
            @(negedge clk);
        end
        chk_eq("R6 R7 static beat_end on time", beat_end, 1);
        chk_eq("R6 end not driven", ackrdy_oe, 0);
        @(negedge clk);
        static_sel = 1'b0;
        @(negedge clk);
        chk_eq("R3 dynamic idle driven again", ackrdy_oe, 1);

        repeat (2) @(negedge clk);
        chk_eq("R13 scoreboard drained", sbq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule